// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Merger

This block forms the top-interrupt report seen by a guest running in virtual supervisor mode on a hypervisor-capable RISC-V hart: one interrupt identity and one 8-bit priority. It weighs an external-interrupt candidate against a local-or-injected candidate. The external candidate stands for the supervisor external interrupt (identity 9). Its priority comes from one of three places: the guest interrupt file's top value, a software-injected priority, or a fixed default of 256 that ranks below every real priority. The local candidate is either the winner of a separate priority scan of the guest's pending-and-enabled interrupts, or an interrupt that the hypervisor injects directly through its control fields.

The comparison uses a widened priority, so that the default of 256 and priorities up to 2047 from the interrupt file compare correctly. A lower value wins. Ties are settled by the fixed default interrupt order when the local candidate comes from the scan, and by an injection tie bit when it is injected. The winning priority is then clamped to 8 bits, or forced to 1 for an injected winner whose priority is not meant to be shown. The merged result is registered, so it appears one clock after the inputs. The scan that produces the local winner sits outside this block.

Top module: `vs_topi_merger`

## Requirements
- R1: The guest-file candidate is active when vs_pend[9], vs_en[9], a nonzero guest_sel and a nonzero guest_top are all present. Its priority is guest_top[10:0].
- R2: The software candidate is active when vs_pend[9] and vs_en[9] are set, guest_sel is zero, inj_iid equals 9 and inj_prio is nonzero. Its priority is inj_prio.
- R3: When vs_pend[9] and vs_en[9] are set and neither R1 nor R2 applies, the external candidate takes the default priority 256.
- R4: Whenever the external candidate wins, the reported identity is 9.
- R5: The scan candidate is active when inj_vti is 0 and (vs_pend & vs_en) has any set bit other than bit 9. It reports scan_id and scan_prio.
- R6: The injected candidate is active when inj_vti is 1 and inj_iid is not 9. It reports inj_iid and inj_prio.
- R7: External against scan: the lower priority wins. On equal priorities the external candidate wins if identity 9 stands at or before scan_id in the fixed default order. Positions used: identity 11 at 24, identity 9 at 27, identity 1 at 28.
- R8: External against injected: the lower priority wins. On equal priorities the external candidate wins when inj_dpr is 1, and the injected one wins otherwise.
- R9: With no active candidate, topi_id and topi_prio are both 0.
- R10: A winning priority above 255 is reported as 255. Otherwise the low 8 bits are reported.
- R11: If the injected candidate wins while inj_ipriom is 0, topi_prio is 1.
- R12: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge, and are 0 in the cycle after rst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_pend | input | 64 | Guest-level pending interrupt vector |
| vs_en | input | 64 | Guest-level interrupt enable vector |
| guest_sel | input | 6 | Selected guest interrupt file, 0 for none |
| guest_top | input | 32 | Top value of the guest interrupt file, priority in bits 10:0 |
| inj_vti | input | 1 | Injected-interrupt mode select |
| inj_iid | input | 12 | Injected interrupt identity |
| inj_dpr | input | 1 | Tie bit: external wins equal priority when 1 |
| inj_ipriom | input | 1 | Show injected priority when 1, else report 1 |
| inj_prio | input | 8 | Injected priority |
| scan_id | input | 12 | Identity of the local-scan winner |
| scan_prio | input | 8 | Priority of the local-scan winner |
| topi_id | output | 12 | Reported interrupt identity |
| topi_prio | output | 8 | Reported priority |

## Verification
The bench sweeps every combination of external-source selection, guest top values (zero, small, above 255, and nonzero with a zero priority field), injection fields, and scan winners placed on either side of identity 9 in the default order. It compares each result against an arithmetic model. Equal priorities are driven on purpose. A design that confused the tie direction would hand the report to the wrong candidate. One that compared only 8 bits would let the default 256 or a 0x190 guest priority beat a real local interrupt. A design that did not mask bit 9 from the scan activity would report a local winner when only the external interrupt is pending. Missing the clamp or the forced 1 would leak raw priority bits.

// File: rtl/vstopi_pkg.sv
package vstopi_pkg;

    localparam int unsigned ID_W      = 12;
    localparam int unsigned CMP_W     = 12;
    localparam int unsigned EXT_PW    = 11;
    localparam int unsigned OUT_PW    = 8;
    localparam int unsigned ORDER_LEN = 61;
    localparam int unsigned RANK_W    = $clog2(ORDER_LEN);
    localparam int unsigned SEI_ID    = 9;
    localparam int unsigned DFLT_PRIO = 256;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_GUEST,
        SRC_SOFT,
        SRC_DFLT,
        SRC_SCAN,
        SRC_INJ
    } src_e;

    typedef struct packed {
        logic             act;
        src_e             src;
        logic [ID_W-1:0]  id;
        logic [CMP_W-1:0] prio;
    } cand_t;

    // Triplet blocks: (hi-2k, lo-k, hi-1-2k) for k = off/3
    function automatic logic [ID_W-1:0] trip_id(input int hi, input int lo, input int off);
        int k;
        int r;
        k = off / 3;
        r = off % 3;
        if (r == 0)      return ID_W'(hi - 2 * k);
        else if (r == 1) return ID_W'(lo - k);
        else             return ID_W'(hi - 1 - 2 * k);
    endfunction

    function automatic logic [ID_W-1:0] arch_id(input int off);
        case (off)
            0:  return ID_W'(11);
            1:  return ID_W'(3);
            2:  return ID_W'(7);
            3:  return ID_W'(9);
            4:  return ID_W'(1);
            5:  return ID_W'(5);
            6:  return ID_W'(12);
            7:  return ID_W'(10);
            8:  return ID_W'(2);
            9:  return ID_W'(6);
            10: return ID_W'(13);
            11: return ID_W'(14);
            default: return ID_W'(15);
        endcase
    endfunction

    // Identity held at a given position of the fixed default order
    function automatic logic [ID_W-1:0] order_id(input int pos);
        if (pos < 6)       return trip_id(63, 31, pos);
        else if (pos < 18) return trip_id(47, 23, pos - 6);
        else if (pos < 24) return trip_id(59, 29, pos - 18);
        else if (pos < 37) return arch_id(pos - 24);
        else if (pos < 43) return trip_id(55, 27, pos - 37);
        else if (pos < 55) return trip_id(39, 19, pos - 43);
        else               return trip_id(51, 25, pos - 55);
    endfunction

    // Position of an identity in the default order; unknown identities rank 0
    function automatic logic [RANK_W-1:0] rank_of(input logic [ID_W-1:0] id);
        logic [RANK_W-1:0] r;
        r = '0;
        for (int i = 0; i < int'(ORDER_LEN); i++) begin
            if (order_id(i) == id) r = RANK_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vs_ext_select.sv
module vs_ext_select
    import vstopi_pkg::*;
#(
    parameter int unsigned GSEL_W = 6,
    parameter int unsigned TOP_W  = 32
) (
    input  logic              sei_pend,
    input  logic              sei_en,
    input  logic [GSEL_W-1:0] guest_sel,
    input  logic [TOP_W-1:0]  guest_top,
    input  logic [ID_W-1:0]   inj_iid,
    input  logic [OUT_PW-1:0] inj_prio,
    output cand_t             ext_c
);
    localparam int unsigned PAD_G = CMP_W - EXT_PW;
    localparam int unsigned PAD_S = CMP_W - OUT_PW;

    logic sei_live;
    logic from_guest;
    logic from_soft;

    always_comb begin
        sei_live   = sei_pend && sei_en;
        from_guest = sei_live && (guest_sel != '0) && (guest_top != '0);
        from_soft  = sei_live && (guest_sel == '0) && (inj_iid == ID_W'(SEI_ID))
                     && (inj_prio != '0);

        ext_c.act = sei_live;
        ext_c.id  = sei_live ? ID_W'(SEI_ID) : '0;
        if (from_guest) begin
            ext_c.src  = SRC_GUEST;
            ext_c.prio = {{PAD_G{1'b0}}, guest_top[EXT_PW-1:0]};
        end else if (from_soft) begin
            ext_c.src  = SRC_SOFT;
            ext_c.prio = {{PAD_S{1'b0}}, inj_prio};
        end else if (sei_live) begin
            ext_c.src  = SRC_DFLT;
            ext_c.prio = CMP_W'(DFLT_PRIO);
        end else begin
            ext_c.src  = SRC_NONE;
            ext_c.prio = '0;
        end
    end

endmodule

// File: rtl/vs_local_select.sv
module vs_local_select
    import vstopi_pkg::*;
#(
    parameter int unsigned NIRQ = 64
) (
    input  logic [NIRQ-1:0]   vs_pend,
    input  logic [NIRQ-1:0]   vs_en,
    input  logic              inj_vti,
    input  logic [ID_W-1:0]   inj_iid,
    input  logic [OUT_PW-1:0] inj_prio,
    input  logic [ID_W-1:0]   scan_id,
    input  logic [OUT_PW-1:0] scan_prio,
    output cand_t             loc_c
);
    localparam int unsigned PAD_L = CMP_W - OUT_PW;
    localparam logic [NIRQ-1:0] SEI_MASK = ~(NIRQ'(1) << SEI_ID);

    logic [NIRQ-1:0] live_local;
    logic            use_scan;
    logic            use_inj;

    always_comb begin
        live_local = vs_pend & vs_en & SEI_MASK;
        use_scan   = !inj_vti && (live_local != '0);
        use_inj    = inj_vti && (inj_iid != ID_W'(SEI_ID));

        loc_c.act = use_scan || use_inj;
        if (use_scan) begin
            loc_c.src  = SRC_SCAN;
            loc_c.id   = scan_id;
            loc_c.prio = {{PAD_L{1'b0}}, scan_prio};
        end else if (use_inj) begin
            loc_c.src  = SRC_INJ;
            loc_c.id   = inj_iid;
            loc_c.prio = {{PAD_L{1'b0}}, inj_prio};
        end else begin
            loc_c.src  = SRC_NONE;
            loc_c.id   = '0;
            loc_c.prio = '0;
        end
    end

endmodule

// File: rtl/vs_top_merge.sv
module vs_top_merge
    import vstopi_pkg::*;
(
    input  cand_t             ext_c,
    input  cand_t             loc_c,
    input  logic              inj_dpr,
    input  logic              inj_ipriom,
    output logic [ID_W-1:0]   win_id,
    output logic [OUT_PW-1:0] win_prio
);
    localparam logic [RANK_W-1:0] SEI_RANK = rank_of(ID_W'(SEI_ID));

    logic             prio_lt;
    logic             prio_eq;
    logic             tie_ext;
    logic             ext_wins;
    logic [CMP_W-1:0] sel_prio;

    always_comb begin
        prio_lt = ext_c.prio < loc_c.prio;
        prio_eq = ext_c.prio == loc_c.prio;
        if (loc_c.src == SRC_SCAN) tie_ext = SEI_RANK <= rank_of(loc_c.id);
        else                       tie_ext = inj_dpr;
        ext_wins = ext_c.act && (!loc_c.act || prio_lt || (prio_eq && tie_ext));

        win_id   = '0;
        win_prio = '0;
        sel_prio = '0;
        if (ext_wins) begin
            win_id   = ext_c.id;
            sel_prio = ext_c.prio;
        end else if (loc_c.act) begin
            win_id   = loc_c.id;
            sel_prio = loc_c.prio;
        end
        if (sel_prio > CMP_W'(255))
            win_prio = '1;
        else if (!ext_wins && loc_c.src == SRC_INJ && !inj_ipriom)
            win_prio = OUT_PW'(1);
        else
            win_prio = sel_prio[OUT_PW-1:0];
    end

endmodule

// File: rtl/vs_topi_merger.sv
module vs_topi_merger
    import vstopi_pkg::*;
#(
    parameter int unsigned NIRQ   = 64,
    parameter int unsigned GSEL_W = 6,
    parameter int unsigned TOP_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIRQ-1:0]   vs_pend,
    input  logic [NIRQ-1:0]   vs_en,
    input  logic [GSEL_W-1:0] guest_sel,
    input  logic [TOP_W-1:0]  guest_top,
    input  logic              inj_vti,
    input  logic [ID_W-1:0]   inj_iid,
    input  logic              inj_dpr,
    input  logic              inj_ipriom,
    input  logic [OUT_PW-1:0] inj_prio,
    input  logic [ID_W-1:0]   scan_id,
    input  logic [OUT_PW-1:0] scan_prio,
    output logic [ID_W-1:0]   topi_id,
    output logic [OUT_PW-1:0] topi_prio
);
    cand_t             ext_c;
    cand_t             loc_c;
    logic [ID_W-1:0]   win_id;
    logic [OUT_PW-1:0] win_prio;

    vs_ext_select #(.GSEL_W(GSEL_W), .TOP_W(TOP_W)) u_ext (
        .sei_pend (vs_pend[SEI_ID]),
        .sei_en   (vs_en[SEI_ID]),
        .guest_sel(guest_sel),
        .guest_top(guest_top),
        .inj_iid  (inj_iid),
        .inj_prio (inj_prio),
        .ext_c    (ext_c)
    );

    vs_local_select #(.NIRQ(NIRQ)) u_loc (
        .vs_pend  (vs_pend),
        .vs_en    (vs_en),
        .inj_vti  (inj_vti),
        .inj_iid  (inj_iid),
        .inj_prio (inj_prio),
        .scan_id  (scan_id),
        .scan_prio(scan_prio),
        .loc_c    (loc_c)
    );

    vs_top_merge u_merge (
        .ext_c     (ext_c),
        .loc_c     (loc_c),
        .inj_dpr   (inj_dpr),
        .inj_ipriom(inj_ipriom),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            topi_id   <= '0;
            topi_prio <= '0;
        end else begin
            topi_id   <= win_id;
            topi_prio <= win_prio;
        end
    end

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (topi_id == '0 && topi_prio == '0));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!ext_c.act && !loc_c.act) |=> (topi_id == '0 && topi_prio == '0));

    assert_ext_alone_id_R4: assert property (@(posedge clk) disable iff (rst)
        (ext_c.act && !loc_c.act) |=> (topi_id == ID_W'(SEI_ID)));

    assert_clamp_high_R10: assert property (@(posedge clk) disable iff (rst)
        (ext_c.act && !loc_c.act && ext_c.prio > CMP_W'(255)) |=> (topi_prio == '1));

    assert_inj_hidden_prio_R11: assert property (@(posedge clk) disable iff (rst)
        (!ext_c.act && loc_c.src == SRC_INJ && !inj_ipriom) |=> (topi_prio == OUT_PW'(1)));

    assert_scan_alone_id_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_c.act && loc_c.src == SRC_SCAN) |=> (topi_id == $past(scan_id)));

endmodule

// File: tb/test_vs_topi_merger.sv
module test_vs_topi_merger;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] vs_pend = '0;
    logic [63:0] vs_en = '0;
    logic [5:0]  guest_sel = '0;
    logic [31:0] guest_top = '0;
    logic        inj_vti = 1'b0;
    logic [11:0] inj_iid = '0;
    logic        inj_dpr = 1'b0;
    logic        inj_ipriom = 1'b0;
    logic [7:0]  inj_prio = '0;
    logic [11:0] scan_id = '0;
    logic [7:0]  scan_prio = '0;
    logic [11:0] topi_id;
    logic [7:0]  topi_prio;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    vs_topi_merger i_vs_topi_merger (
        .clk(clk), .rst(rst), .vs_pend(vs_pend), .vs_en(vs_en),
        .guest_sel(guest_sel), .guest_top(guest_top), .inj_vti(inj_vti),
        .inj_iid(inj_iid), .inj_dpr(inj_dpr), .inj_ipriom(inj_ipriom),
        .inj_prio(inj_prio), .scan_id(scan_id), .scan_prio(scan_prio),
        .topi_id(topi_id), .topi_prio(topi_prio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Default-order positions used by the stimulus (R7)
    function automatic int pos_of(input logic [11:0] id);
        if (id == 12'd9)  return 27;
        if (id == 12'd1)  return 28;
        if (id == 12'd11) return 24;
        return 0;
    endfunction

    task automatic expect_out(input string tag, input logic [11:0] eid, input logic [7:0] ep);
        n_checks = n_checks + 1;
        if (topi_id !== eid || topi_prio !== ep) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got id=%0d prio=%0d expected id=%0d prio=%0d",
                     tag, topi_id, topi_prio, eid, ep);
        end
    endtask

    // Model of the requirements; returns the requirement tag that decided
    task automatic model(output logic [11:0] eid, output logic [7:0] ep, output string tag);
        bit sei, c1, c2, c4, c5, ewin;
        int xp, lp;
        sei = vs_pend[9] && vs_en[9];
        c1  = sei && guest_sel != 0 && guest_top != 0;                 // R1
        c2  = sei && guest_sel == 0 && inj_iid == 9 && inj_prio != 0;  // R2
        xp  = c1 ? int'(guest_top[10:0]) : (c2 ? int'(inj_prio) : 256); // R3
        c4  = !inj_vti && (((vs_pend & vs_en) & ~(64'd1 << 9)) != 0);  // R5
        c5  = inj_vti && inj_iid != 9;                                  // R6
        lp  = c4 ? int'(scan_prio) : int'(inj_prio);
        if (!sei && !c4 && !c5) begin
            eid = 0; ep = 0; tag = "R9"; return;
        end
        if (!sei) ewin = 1'b0;
        else if (!c4 && !c5) ewin = 1'b1;
        else if (c4) ewin = xp < lp || (xp == lp && pos_of(12'd9) <= pos_of(scan_id)); // R7
        else         ewin = xp < lp || (xp == lp && inj_dpr);                        // R8
        if (ewin) begin
            eid = 12'd9;                                      // R4
            ep  = xp > 255 ? 8'hFF : 8'(xp);                  // R10
            tag = c1 ? "R1/R4/R10" : (c2 ? "R2/R4" : "R3/R4/R10");
        end else if (c4) begin
            eid = scan_id; ep = 8'(lp); tag = sei ? "R7" : "R5";
        end else begin
            eid = inj_iid; ep = inj_ipriom ? 8'(lp) : 8'd1;   // R11
            tag = sei ? "R8/R11" : "R6/R11";
        end
    endtask

    initial begin
        logic [11:0] eid;
        logic [7:0]  ep;
        string       tag;
        logic [31:0] tops [4];
        logic [11:0] iids [3];
        logic [7:0]  iprs [3];
        tops[0] = 32'h0; tops[1] = 32'h0007_0005; tops[2] = 32'h0003_0190; tops[3] = 32'h0002_0000;
        iids[0] = 12'd9; iids[1] = 12'd3; iids[2] = 12'd13;
        iprs[0] = 8'd0;  iprs[1] = 8'd5;  iprs[2] = 8'd200;

        repeat (3) @(negedge clk);
        expect_out("R12 reset", 12'd0, 8'd0);
        rst = 1'b0;

        for (int sp = 0; sp < 2; sp++)
        for (int se = 0; se < 2; se++)
        for (int g = 0; g < 2; g++)
        for (int t = 0; t < 4; t++)
        for (int v = 0; v < 2; v++)
        for (int ii = 0; ii < 3; ii++)
        for (int ip = 0; ip < 3; ip++)
        for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
        for (int o = 0; o < 3; o++)
        for (int s = 0; s < 2; s++)
        for (int q = 0; q < 2; q++) begin
            @(negedge clk);
            vs_pend    = (o == 1) ? 64'h2 : ((o == 2) ? 64'h20 : 64'h0);
            vs_en      = (o == 0) ? 64'h0 : 64'h2;
            vs_pend[9] = sp[0];
            vs_en[9]   = se[0];
            guest_sel  = g[0] ? 6'd3 : 6'd0;
            guest_top  = tops[t];
            inj_vti    = v[0];
            inj_iid    = iids[ii];
            inj_prio   = iprs[ip];
            inj_dpr    = d[0];
            inj_ipriom = m[0];
            scan_id    = s[0] ? 12'd11 : 12'd1;
            scan_prio  = q[0] ? 8'd200 : 8'd5;
            model(eid, ep, tag);
            @(negedge clk);
            expect_out(tag, eid, ep);
        end

        // R12: reset mid-run clears an active report
        @(negedge clk);
        vs_pend = 64'h200; vs_en = 64'h200; guest_sel = 0; inj_vti = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        expect_out("R12 mid-run reset", 12'd0, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R12 release R3", 12'd9, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule